// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block stands between a processor core's reset logic and the read port of its memory. After every reset it reads a 32-bit start address from one of two fixed locations in a memory-mapped boot ROM, loads that value into the program counter, and only then lets the core run. The word read from the fixed location is never executed. It is an indirection: the loaded value is where execution begins.

Two resets are told apart. A power-on reset clears everything, including a sticky flag that records that power has been up and that a start address was loaded at least once. A warm reset, such as one raised after a fatal fault, leaves that flag alone. When the flag is set, a warm reset selects the warm vector, so the restart can bypass the cold-boot self-test code. The memory port is narrower than the vector. The word is collected in little-endian beats, and each beat is one single-cycle request followed by a response that may take any number of cycles.

Top module: `bootVecSeq`

## Requirements
- R1: After a power-on reset is released, the first read request goes to address 0x000FFFF4 (the cold vector).
- R2: After a warm reset, once a start address has already been loaded since the last power-on reset, the first read request goes to address 0x000FFFF0 (the warm vector).
- R3: A warm reset that arrives before any start address has been loaded since power-on restarts from the cold vector. When both reset inputs are asserted together, power-on wins and the cold vector is used.
- R4: The 32-bit vector is read as BUS_W-bit beats (default 16, so two beats) at the vector address plus k*2 bytes. Beat k supplies bits [16k+15:16k]. The assembled value appears on pcOut in the single cycle in which pcLoad is high, and pcOut holds it until the next load.
- R5: Each beat issues rdReq for exactly one cycle. The next beat is not requested until rdValid has returned the previous one, whatever the latency. A full fetch makes exactly BEATS requests.
- R6: coreRun is low from reset through the cycle in which pcLoad is high. It goes high in the following cycle and stays high until a reset input is asserted.
- R7: A reset asserted while a fetch is pending aborts it. A response that arrives while the sequencer is not waiting for one is discarded, and the fetch restarts from the first beat of the vector chosen for the new reset.
- R8: While either reset input is high, rdReq, pcLoad and coreRun are low. A power-on reset clears pcOut to 0.
- R9: Once running, the sequencer issues no further read requests or PC loads until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| powerOnRst | input | 1 | Synchronous power-on (cold) reset, active high |
| warmRst | input | 1 | Synchronous warm reset, active high |
| rdReq | output | 1 | Single-cycle read request to the boot ROM |
| rdAddr | output | 32 | Byte address of the requested beat |
| rdValid | input | 1 | Read response strobe |
| rdData | input | 16 | Read response data (BUS_W bits) |
| pcOut | output | 32 | Program counter value loaded from the vector |
| pcLoad | output | 1 | One-cycle strobe marking pcOut as the new start address |
| coreRun | output | 1 | Enable that lets the core execute |

## Verification
The embedded properties check, on every cycle, that requests and load strobes last a single cycle, that the run enable rises only right after a load, that nothing is requested or loaded while running, that a warm reset silences the outputs, and that the warm vector is never selected unless the power-good flag is set. Which address the fetch starts from, the little-endian order of the beats, the loaded value, and the discarding of a stale response after an aborted fetch depend on memory contents and reset history. Only the bench's scenarios show these: cold boot, warm boot, a warm reset during the first cold fetch, simultaneous resets, long latency, and an abort while a response is still in flight.

// File: rtl/bootVecPkg.sv
package bootVecPkg;

  typedef enum logic [2:0] {
    IDLE_RESET = 3'd0,
    ISSUE_READ = 3'd1,
    WAIT_DATA  = 3'd2,
    LOAD_PC    = 3'd3,
    RUN        = 3'd4
  } seqState_t;

  // strobes from the control FSM to the vector datapath
  typedef struct packed {
    logic clearAll;  // power-on clear of every datapath register
    logic restart;   // rewind beat index and scratch word
    logic selWarm;   // pick the warm vector base
    logic capture;   // accept rdData into the current beat slot
    logic commit;    // copy the completed word into the PC register
  } pathCtrl_t;

endpackage

// File: rtl/bootVecPath.sv
module bootVecPath
  import bootVecPkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          VEC_W    = 32,
  parameter int          BUS_W    = 16,
  parameter logic [31:0] COLD_VEC = 32'h000F_FFF4,
  parameter logic [31:0] WARM_VEC = 32'h000F_FFF0
) (
  input  logic              clk,
  input  pathCtrl_t         ctl,
  input  logic [BUS_W-1:0]  rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              lastBeat,
  output logic [VEC_W-1:0]  pcValue
);

  localparam int BEATS      = VEC_W / BUS_W;
  localparam int BEAT_BYTES = BUS_W / 8;
  localparam int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BEAT_W-1:0] beatIdx;
  logic [VEC_W-1:0]  vecWord;
  logic [VEC_W-1:0]  nextWord;
  logic [VEC_W-1:0]  pcReg;
  logic [ADDR_W-1:0] baseAddr;

  assign baseAddr = ctl.selWarm ? ADDR_W'(WARM_VEC) : ADDR_W'(COLD_VEC);
  assign rdAddr   = baseAddr + ADDR_W'(beatIdx) * ADDR_W'(BEAT_BYTES);
  assign lastBeat = (beatIdx == BEAT_W'(BEATS - 1));

  // little-endian placement: beat g fills slice g of the vector word
  for (genvar g = 0; g < BEATS; g++) begin : gBeat
    assign nextWord[g*BUS_W +: BUS_W] =
      (ctl.capture && beatIdx == BEAT_W'(g)) ? rdData : vecWord[g*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (ctl.clearAll) begin
      beatIdx <= '0;
      vecWord <= '0;
      pcReg   <= '0;
    end else begin
      if (ctl.restart) begin
        beatIdx <= '0;
        vecWord <= '0;
      end
      if (ctl.capture) begin
        vecWord <= nextWord;
        beatIdx <= lastBeat ? '0 : beatIdx + BEAT_W'(1);
      end
      if (ctl.commit) begin
        pcReg <= nextWord;
      end
    end
  end

  assign pcValue = pcReg;

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (ctl.clearAll)
    !ctl.commit |=> $stable(pcValue));

  // R5
  beat_advance_chk: assert property (@(posedge clk) disable iff (ctl.clearAll)
    (!ctl.capture && !ctl.restart) |=> $stable(beatIdx));

endmodule

// File: rtl/bootVecCtrl.sv
module bootVecCtrl
  import bootVecPkg::*;
(
  input  logic      clk,
  input  logic      powerOnRst,
  input  logic      warmRst,
  input  logic      rdValid,
  input  logic      lastBeat,
  output pathCtrl_t ctl,
  output logic      rdReq,
  output logic      pcLoad,
  output logic      coreRun
);

  seqState_t state;
  seqState_t nextState;
  logic      powerGood;
  logic      warmSel;
  logic      anyRst;

  assign anyRst = powerOnRst | warmRst;

  always_comb begin
    nextState = state;
    unique case (state)
      IDLE_RESET: nextState = ISSUE_READ;
      ISSUE_READ: nextState = WAIT_DATA;
      WAIT_DATA:  if (rdValid) nextState = lastBeat ? LOAD_PC : ISSUE_READ;
      LOAD_PC:    nextState = RUN;
      RUN:        nextState = RUN;
      default:    nextState = IDLE_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (powerOnRst) begin
      state     <= IDLE_RESET;
      powerGood <= 1'b0;
      warmSel   <= 1'b0;
    end else if (warmRst) begin
      state   <= IDLE_RESET;
      warmSel <= powerGood;
    end else begin
      state <= nextState;
      if (state == LOAD_PC) powerGood <= 1'b1;
    end
  end

  assign rdReq   = (state == ISSUE_READ) && !anyRst;
  assign pcLoad  = (state == LOAD_PC) && !anyRst;
  assign coreRun = (state == RUN) && !anyRst;

  always_comb begin
    ctl.clearAll = powerOnRst;
    ctl.restart  = (state == IDLE_RESET);
    ctl.selWarm  = warmSel;
    ctl.capture  = (state == WAIT_DATA) && rdValid && !anyRst;
    ctl.commit   = ctl.capture && lastBeat;
  end

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (powerOnRst)
    rdReq |=> !rdReq);

  // R4
  load_pulse_chk: assert property (@(posedge clk) disable iff (powerOnRst)
    pcLoad |=> !pcLoad);

  // R6
  run_after_load_chk: assert property (@(posedge clk) disable iff (powerOnRst)
    $rose(coreRun) |-> $past(pcLoad));

  // R9
  run_quiet_chk: assert property (@(posedge clk) disable iff (powerOnRst)
    coreRun |=> (!pcLoad && !rdReq));

  // R8
  warm_quiet_chk: assert property (@(posedge clk) disable iff (powerOnRst)
    warmRst |=> (!coreRun && !pcLoad));

  // R3
  warm_needs_good_chk: assert property (@(posedge clk) disable iff (powerOnRst)
    warmSel |-> powerGood);

endmodule

// File: rtl/bootVecSeq.sv
module bootVecSeq
  import bootVecPkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          VEC_W    = 32,
  parameter int          BUS_W    = 16,
  parameter logic [31:0] COLD_VEC = 32'h000F_FFF4,
  parameter logic [31:0] WARM_VEC = 32'h000F_FFF0
) (
  input  logic              clk,
  input  logic              powerOnRst,
  input  logic              warmRst,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [BUS_W-1:0]  rdData,
  output logic [VEC_W-1:0]  pcOut,
  output logic              pcLoad,
  output logic              coreRun
);

  pathCtrl_t ctl;
  logic      lastBeat;

  bootVecCtrl ctrl_i (
    .clk        (clk),
    .powerOnRst (powerOnRst),
    .warmRst    (warmRst),
    .rdValid    (rdValid),
    .lastBeat   (lastBeat),
    .ctl        (ctl),
    .rdReq      (rdReq),
    .pcLoad     (pcLoad),
    .coreRun    (coreRun)
  );

  bootVecPath #(
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .BUS_W    (BUS_W),
    .COLD_VEC (COLD_VEC),
    .WARM_VEC (WARM_VEC)
  ) path_i (
    .clk      (clk),
    .ctl      (ctl),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .lastBeat (lastBeat),
    .pcValue  (pcOut)
  );

endmodule

// File: tb/bootVecSeq_tb_top.sv
module bootVecSeq_tb_top;

  localparam logic [31:0] COLD = 32'h000F_FFF4;
  localparam logic [31:0] WARM = 32'h000F_FFF0;

  logic        clk = 1'b0;
  logic        powerOnRst = 1'b1;
  logic        warmRst = 1'b0;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [15:0] rdData = '0;
  logic [31:0] pcOut;
  logic        pcLoad;
  logic        coreRun;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bootVecSeq dut_i (
    .clk(clk), .powerOnRst(powerOnRst), .warmRst(warmRst),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .pcOut(pcOut), .pcLoad(pcLoad), .coreRun(coreRun)
  );

  // boot ROM model
  logic [31:0] coldVal = 32'h0000_1230;
  logic [31:0] warmVal = 32'h0000_3210;
  logic [31:0] reqLog [0:255];
  int          nReads = 0;
  int          memLat = 0;
  int          cnt = 0;
  bit          busy = 0;
  logic [15:0] pendData = '0;

  function automatic logic [15:0] romHalf(input logic [31:0] a);
    logic [31:0] w;
    if (a[31:2] == WARM[31:2])      w = warmVal;
    else if (a[31:2] == COLD[31:2]) w = coldVal;
    else                            w = 32'hDEAD_BEEF;
    return a[1] ? w[31:16] : w[15:0];
  endfunction

  always @(posedge clk) begin
    #1;
    rdValid = 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        rdValid = 1'b1;
        rdData  = pendData;
        busy    = 0;
      end else cnt--;
    end
    if (rdReq) begin
      reqLog[nReads % 256] = rdAddr;
      nReads++;
      busy     = 1;
      cnt      = memLat;
      pendData = romHalf(rdAddr);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitLoad(input string req, output logic [31:0] pcSeen);
    int n = 0;
    pcSeen = '0;
    while (!pcLoad && n < 300) begin tick(); n++; end
    if (!pcLoad) begin
      chk(1'b0, req, "pcLoad never seen", 32'(pcLoad), 32'd1);
    end else begin
      pcSeen = pcOut;
      chk(coreRun == 1'b0, "R6", "coreRun low in load cycle", 32'(coreRun), 32'd0);
      tick();
      chk(coreRun == 1'b1, "R6", "coreRun high after load", 32'(coreRun), 32'd1);
      chk(pcLoad == 1'b0, "R4", "load strobe one cycle", 32'(pcLoad), 32'd0);
    end
  endtask

  task automatic waitReq();
    int n = 0;
    while (!rdReq && n < 100) begin tick(); n++; end
  endtask

  task automatic tResetState();
    powerOnRst = 1'b1;
    repeat (4) tick();
    chk(rdReq == 1'b0, "R8", "no request in reset", 32'(rdReq), 32'd0);
    chk(pcLoad == 1'b0, "R8", "no load in reset", 32'(pcLoad), 32'd0);
    chk(coreRun == 1'b0, "R8", "core held in reset", 32'(coreRun), 32'd0);
    chk(pcOut == 32'd0, "R8", "pcOut cleared", pcOut, 32'd0);
  endtask

  task automatic tColdBoot();
    logic [31:0] pc;
    int base = nReads;
    powerOnRst = 1'b0;
    waitLoad("R1", pc);
    chk(reqLog[base % 256] == COLD, "R1", "cold vector first address", reqLog[base % 256], COLD);
    chk(reqLog[(base+1) % 256] == COLD + 2, "R4", "upper beat address", reqLog[(base+1) % 256], COLD + 2);
    chk(pc == coldVal, "R4", "cold start address loaded", pc, coldVal);
    chk(nReads - base == 2, "R5", "two requests per fetch", 32'(nReads - base), 32'd2);
    base = nReads;
    repeat (20) tick();
    chk(coreRun == 1'b1, "R6", "coreRun stays high", 32'(coreRun), 32'd1);
    chk(nReads == base, "R9", "no reads while running", 32'(nReads - base), 32'd0);
    chk(pcOut == coldVal, "R4", "pcOut holds", pcOut, coldVal);
  endtask

  task automatic tWarmBoot();
    logic [31:0] pc;
    int base;
    warmRst = 1'b1;
    tick();
    chk(coreRun == 1'b0, "R8", "core stopped by warm reset", 32'(coreRun), 32'd0);
    base = nReads;
    warmRst = 1'b0;
    waitLoad("R2", pc);
    chk(reqLog[base % 256] == WARM, "R2", "warm vector first address", reqLog[base % 256], WARM);
    chk(pc == warmVal, "R2", "warm start address loaded", pc, warmVal);
  endtask

  task automatic tEarlyWarm();
    logic [31:0] pc;
    int base;
    memLat = 2;
    powerOnRst = 1'b1;
    repeat (2) tick();
    powerOnRst = 1'b0;
    waitReq();
    tick();
    warmRst = 1'b1;
    repeat (6) tick();
    base = nReads;
    warmRst = 1'b0;
    waitLoad("R3", pc);
    chk(reqLog[base % 256] == COLD, "R3", "warm before power good uses cold", reqLog[base % 256], COLD);
    chk(pc == coldVal, "R7", "restarted fetch value", pc, coldVal);
    chk(nReads - base == 2, "R7", "restart fetches from first beat", 32'(nReads - base), 32'd2);
  endtask

  task automatic tAbortStale();
    logic [31:0] pc;
    int base;
    memLat = 3;
    warmRst = 1'b1;
    tick();
    warmRst = 1'b0;
    waitReq();
    tick();
    warmVal = 32'h00AB_CDEF;
    warmRst = 1'b1;
    repeat (8) tick();
    base = nReads;
    warmRst = 1'b0;
    waitLoad("R7", pc);
    chk(pc == 32'h00AB_CDEF, "R7", "stale response dropped", pc, 32'h00AB_CDEF);
    chk(reqLog[base % 256] == WARM, "R2", "warm vector after abort", reqLog[base % 256], WARM);
  endtask

  task automatic tBothResets();
    logic [31:0] pc;
    int base;
    memLat = 0;
    powerOnRst = 1'b1;
    warmRst = 1'b1;
    repeat (3) tick();
    chk(pcOut == 32'd0, "R8", "pcOut cleared by power-on", pcOut, 32'd0);
    base = nReads;
    powerOnRst = 1'b0;
    warmRst = 1'b0;
    waitLoad("R3", pc);
    chk(reqLog[base % 256] == COLD, "R3", "simultaneous resets choose cold", reqLog[base % 256], COLD);
  endtask

  task automatic tLongLatency();
    logic [31:0] pc;
    int base;
    memLat = 7;
    coldVal = 32'h8765_4321;
    powerOnRst = 1'b1;
    repeat (2) tick();
    base = nReads;
    powerOnRst = 1'b0;
    waitLoad("R5", pc);
    chk(nReads - base == 2, "R5", "one request per beat under latency", 32'(nReads - base), 32'd2);
    chk(pc == 32'h8765_4321, "R4", "little-endian assembly", pc, 32'h8765_4321);
    chk(reqLog[base % 256] == COLD, "R1", "cold vector after power-on", reqLog[base % 256], COLD);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    tResetState();
    tColdBoot();
    tWarmBoot();
    tEarlyWarm();
    tAbortStale();
    tBothResets();
    tLongLatency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule